// File: doc/BRIEF.md
# Multi-Slot Instruction Fetch and Stall Controller

This block decides each cycle how many instructions of one thread go into the instruction window. The fetch width is fixed, and the instructions come from consecutive slots starting at the current program counter. For each slot, the fetch path supplies a decoded class code and a response code from instruction memory. The window supplies its occupancy and how many entries are free. Processing runs from slot 0 upward. It stops at the first condition that ends the cycle: the window has no room, memory reports a miss or a translation fault, the address is misaligned, or the instruction just fetched raises a stall.

The block keeps a set of sticky stall flags, one per cause. Each flag clears only on its own bit of `clr_i`. While any flag is set, no slot is dispatched, and `stall_code_o` reports the cause with the highest priority.

Branches and calls load a delay countdown. When the delay slots have been fetched, the block issues a branch request with the return address. It then either waits for the redirect or, if a likely-branch target is known, jumps to that target directly. System, coprocessor-0, FP-control and store-conditional instructions serialise fetch. All of these except store-conditional also mark their slot for a pipeline flush.

Top module: `fetch_ctrl`

## Requirements
- R1: At most FETCH_W slots are dispatched per cycle. While `exc_pend_i` is high, no slot is dispatched.
- R2: Let n be the number of slots already dispatched in the cycle. A slot is attempted only while `occ_i` + n < WIN_DEPTH and n < `free_i`. Once either limit is reached, no later slot is dispatched in that cycle.
- R3: `stall_code_o` reports the first set flag in this priority order: branch wait, FP-control, cache miss, translation, exception, system, coprocessor-0, store-conditional. Branch wait reports 1 when `thread_wait_i` is high and 2 otherwise. The other codes are FP-control=3, cache miss=4, translation=5, exception=6, system=7, coprocessor-0=8, store-conditional=9. With no flag set, the code is 10 when no slot was dispatched that cycle and 0 otherwise.
- R4: A slot reached with PC[1:0] != 0 dispatches nothing, pulses `adr_err_o` and sets the translation flag.
- R5: The response codes are 0=ok, 1=refused, 2=miss and 3=translation fault. A refused slot is lost, and the next slot retries the same PC without setting any flag. A miss sets the cache flag and a fault sets the translation flag; either one ends the cycle.
- R6: Class 1 is branch. A fetched branch loads the delay count with SLOTS+1, and every fetched instruction decrements it. When the count reaches 0 with `likely_vld_i` low, the block pulses `br_req_o` and sets the branch flag. In that cycle `ret_pc_o` equals the branch PC + 4*(SLOTS+1).
- R7: When the delay count reaches 0 with `likely_vld_i` high, the PC is loaded from `likely_pc_i` and no branch stall is set. Fetch then continues from that target in the remaining slots.
- R8: A branch fetched while the delay count is non-zero is dispatched with `disp_ill_o` set. Such a converted branch, or an instruction of class 6, sets the exception flag.
- R9: Each serialising class sets its own flag: 2=system, 3=coprocessor-0, 4=FP-control, 5=store-conditional. Classes 2 to 4 also assert `disp_flush_o` for their slot; class 5 does not.
- R10: Each dispatched slot advances the PC by 4, and classes 0 and 7 are plain. Flags are indexed 0=branch, 1=FP-control, 2=cache miss, 3=translation, 4=exception, 5=system, 6=coprocessor-0, 7=store-conditional. Each flag clears only on `clr_i` at its own index. When the branch flag is set, `clr_i[0]` also loads the PC from `redirect_pc_i`. Fetch resumes once every flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_pend_i | input | 1 | Pending exception; blocks every slot |
| occ_i | input | CNT_W | Current window occupancy |
| free_i | input | CNT_W | Free window entries |
| cls_i | input | 3*FETCH_W | Class code for each slot |
| rsp_i | input | 2*FETCH_W | Instruction memory response for each slot |
| likely_vld_i | input | 1 | A likely-branch target is known |
| likely_pc_i | input | PC_W | Likely-branch target |
| thread_wait_i | input | 1 | Branch wait is due to a thread spawn |
| clr_i | input | 8 | Clear for each stall flag |
| redirect_pc_i | input | PC_W | Resolved branch target |
| disp_vld_o | output | FETCH_W | Dispatch valid for each slot |
| disp_pc_o | output | PC_W*FETCH_W | PC of each slot |
| disp_flush_o | output | FETCH_W | Slot requires a pipeline flush |
| disp_ill_o | output | FETCH_W | Slot converted to an illegal instruction |
| pc_o | output | PC_W | Current fetch PC |
| stall_code_o | output | 4 | Stall reason code |
| br_req_o | output | 1 | Branch resolution request |
| ret_pc_o | output | PC_W | Return address of the pending branch |
| adr_err_o | output | 1 | Misaligned fetch address fault |

## Verification
On every cycle, the assertions check several invariants. A pending exception or any set flag blocks dispatch. The number of dispatched slots never exceeds the free entries, and a set branch flag always shows a branch code. A cache miss stays sticky until its own clear arrives. A branch request, a misaligned address or a converted branch sets the matching flag on the next edge. The bench scenarios are needed to show behaviour that spans whole cycles: stopping at the exact slot where room runs out, a refused slot retrying the same PC, the delay countdown and return address, the jump to a likely target inside a cycle, the ordering between flags that are set together, and redirection after a branch resolves.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int NFLAG = 8;
  localparam int F_BR  = 0;
  localparam int F_FPC = 1;
  localparam int F_IC  = 2;
  localparam int F_XL  = 3;
  localparam int F_EXC = 4;
  localparam int F_SYS = 5;
  localparam int F_CP0 = 6;
  localparam int F_SC  = 7;

  localparam logic [2:0] CLS_BRANCH = 3'd1;
  localparam logic [2:0] CLS_SYS    = 3'd2;
  localparam logic [2:0] CLS_CP0    = 3'd3;
  localparam logic [2:0] CLS_FPC    = 3'd4;
  localparam logic [2:0] CLS_SC     = 3'd5;
  localparam logic [2:0] CLS_ILL    = 3'd6;

  localparam logic [1:0] RSP_OK     = 2'd0;
  localparam logic [1:0] RSP_REFUSE = 2'd1;
  localparam logic [1:0] RSP_MISS   = 2'd2;
  localparam logic [1:0] RSP_FAULT  = 2'd3;

  typedef enum logic [3:0] {
    SC_NONE   = 4'd0,
    SC_BR_THR = 4'd1,
    SC_BRANCH = 4'd2,
    SC_FPC    = 4'd3,
    SC_ICACHE = 4'd4,
    SC_XLAT   = 4'd5,
    SC_EXC    = 4'd6,
    SC_SYS    = 4'd7,
    SC_CP0    = 4'd8,
    SC_STC    = 4'd9,
    SC_OTHER  = 4'd10
  } stall_code_e;
endpackage

// File: rtl/fetch_stall_prio.sv
module fetch_stall_prio
  import fetch_pkg::*;
(
  input  logic [NFLAG-1:0] flags_i,
  input  logic             thread_wait_i,
  input  logic             idle_i,
  output stall_code_e      code_o
);
  always_comb begin
    if (flags_i[F_BR])       code_o = thread_wait_i ? SC_BR_THR : SC_BRANCH;
    else if (flags_i[F_FPC]) code_o = SC_FPC;
    else if (flags_i[F_IC])  code_o = SC_ICACHE;
    else if (flags_i[F_XL])  code_o = SC_XLAT;
    else if (flags_i[F_EXC]) code_o = SC_EXC;
    else if (flags_i[F_SYS]) code_o = SC_SYS;
    else if (flags_i[F_CP0]) code_o = SC_CP0;
    else if (flags_i[F_SC])  code_o = SC_STC;
    else if (idle_i)         code_o = SC_OTHER;
    else                     code_o = SC_NONE;
  end
endmodule

// File: rtl/fetch_slot_step.sv
module fetch_slot_step
  import fetch_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int SLOTS     = 1,
  parameter int WIN_DEPTH = 16,
  parameter int DLY_W     = 2,
  parameter int CNT_W     = 5
) (
  input  logic             run_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [PC_W-1:0]  ret_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [CNT_W-1:0] occ_i,
  input  logic [CNT_W-1:0] free_i,
  input  logic [2:0]       cls_i,
  input  logic [1:0]       rsp_i,
  input  logic             likely_vld_i,
  input  logic [PC_W-1:0]  likely_pc_i,
  output logic             run_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [DLY_W-1:0] dly_o,
  output logic [PC_W-1:0]  ret_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [CNT_W-1:0] n_o,
  output logic             vld_o,
  output logic             flush_o,
  output logic             ill_o,
  output logic             br_req_o,
  output logic             adr_err_o,
  output logic [PC_W-1:0]  slot_pc_o
);
  logic [CNT_W:0] used_w;
  logic           room;
  logic [2:0]     cls_eff;

  assign used_w    = {1'b0, occ_i} + {1'b0, n_i};
  assign room      = (used_w < (CNT_W+1)'(WIN_DEPTH)) && (n_i < free_i);
  assign slot_pc_o = pc_i;

  always_comb begin
    run_o     = run_i;
    pc_o      = pc_i;
    dly_o     = dly_i;
    ret_o     = ret_i;
    flags_o   = flags_i;
    n_o       = n_i;
    vld_o     = 1'b0;
    flush_o   = 1'b0;
    ill_o     = 1'b0;
    br_req_o  = 1'b0;
    adr_err_o = 1'b0;
    cls_eff   = cls_i;
    if (run_i) begin
      if (flags_i != '0 || !room) begin
        run_o = 1'b0;
      end else if (pc_i[1:0] != 2'b00) begin
        adr_err_o     = 1'b1;
        flags_o[F_XL] = 1'b1;
        run_o         = 1'b0;
      end else if (rsp_i == RSP_MISS) begin
        flags_o[F_IC] = 1'b1;
        run_o         = 1'b0;
      end else if (rsp_i == RSP_FAULT) begin
        flags_o[F_XL] = 1'b1;
        run_o         = 1'b0;
      end else if (rsp_i == RSP_OK) begin
        vld_o = 1'b1;
        n_o   = n_i + CNT_W'(1);
        pc_o  = pc_i + PC_W'(4);
        if (dly_i != '0 && cls_i == CLS_BRANCH) begin
          cls_eff = CLS_ILL;
          ill_o   = 1'b1;
        end
        case (cls_eff)
          CLS_BRANCH: begin
            dly_o = DLY_W'(SLOTS + 1);
            ret_o = pc_i + PC_W'(4 * (SLOTS + 1));
          end
          CLS_SYS: begin flags_o[F_SYS] = 1'b1; flush_o = 1'b1; end
          CLS_CP0: begin flags_o[F_CP0] = 1'b1; flush_o = 1'b1; end
          CLS_FPC: begin flags_o[F_FPC] = 1'b1; flush_o = 1'b1; end
          CLS_SC:  flags_o[F_SC] = 1'b1;
          CLS_ILL: flags_o[F_EXC] = 1'b1;
          default: ;
        endcase
        if (dly_o != '0) begin
          dly_o = dly_o - DLY_W'(1);
          if (dly_o == '0) begin
            if (likely_vld_i) pc_o = likely_pc_i;
            else begin
              flags_o[F_BR] = 1'b1;
              br_req_o      = 1'b1;
            end
          end
        end
        if (flags_o != '0) run_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int          FETCH_W   = 4,
  parameter int          SLOTS     = 1,
  parameter int          WIN_DEPTH = 16,
  parameter int          PC_W      = 32,
  parameter logic [31:0] RESET_PC  = 32'h0000_0100,
  localparam int         CNT_W     = $clog2(WIN_DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    exc_pend_i,
  input  logic [CNT_W-1:0]        occ_i,
  input  logic [CNT_W-1:0]        free_i,
  input  logic [3*FETCH_W-1:0]    cls_i,
  input  logic [2*FETCH_W-1:0]    rsp_i,
  input  logic                    likely_vld_i,
  input  logic [PC_W-1:0]         likely_pc_i,
  input  logic                    thread_wait_i,
  input  logic [7:0]              clr_i,
  input  logic [PC_W-1:0]         redirect_pc_i,
  output logic [FETCH_W-1:0]      disp_vld_o,
  output logic [PC_W*FETCH_W-1:0] disp_pc_o,
  output logic [FETCH_W-1:0]      disp_flush_o,
  output logic [FETCH_W-1:0]      disp_ill_o,
  output logic [PC_W-1:0]         pc_o,
  output logic [3:0]              stall_code_o,
  output logic                    br_req_o,
  output logic [PC_W-1:0]         ret_pc_o,
  output logic                    adr_err_o
);
  localparam int DLY_W = $clog2(SLOTS + 2);

  logic [PC_W-1:0]  pc_q, ret_q;
  logic [DLY_W-1:0] dly_q;
  logic [NFLAG-1:0] flags_q, flags_n;

  logic             c_run   [FETCH_W+1];
  logic [PC_W-1:0]  c_pc    [FETCH_W+1];
  logic [DLY_W-1:0] c_dly   [FETCH_W+1];
  logic [PC_W-1:0]  c_ret   [FETCH_W+1];
  logic [NFLAG-1:0] c_flags [FETCH_W+1];
  logic [CNT_W-1:0] c_n     [FETCH_W+1];
  logic [FETCH_W-1:0] s_br, s_adr;
  stall_code_e      code;

  assign c_run[0]   = ~exc_pend_i;
  assign c_pc[0]    = pc_q;
  assign c_dly[0]   = dly_q;
  assign c_ret[0]   = ret_q;
  assign c_flags[0] = flags_q;
  assign c_n[0]     = '0;

  for (genvar s = 0; s < FETCH_W; s++) begin : g_slot
    fetch_slot_step #(
      .PC_W(PC_W), .SLOTS(SLOTS), .WIN_DEPTH(WIN_DEPTH), .DLY_W(DLY_W), .CNT_W(CNT_W)
    ) u_step (
      .run_i(c_run[s]), .pc_i(c_pc[s]), .dly_i(c_dly[s]), .ret_i(c_ret[s]),
      .flags_i(c_flags[s]), .n_i(c_n[s]), .occ_i(occ_i), .free_i(free_i),
      .cls_i(cls_i[3*s +: 3]), .rsp_i(rsp_i[2*s +: 2]),
      .likely_vld_i(likely_vld_i), .likely_pc_i(likely_pc_i),
      .run_o(c_run[s+1]), .pc_o(c_pc[s+1]), .dly_o(c_dly[s+1]), .ret_o(c_ret[s+1]),
      .flags_o(c_flags[s+1]), .n_o(c_n[s+1]),
      .vld_o(disp_vld_o[s]), .flush_o(disp_flush_o[s]), .ill_o(disp_ill_o[s]),
      .br_req_o(s_br[s]), .adr_err_o(s_adr[s]),
      .slot_pc_o(disp_pc_o[PC_W*s +: PC_W])
    );
  end

  assign br_req_o  = |s_br;
  assign adr_err_o = |s_adr;
  assign ret_pc_o  = c_ret[FETCH_W];
  assign pc_o      = pc_q;

  fetch_stall_prio u_prio (
    .flags_i(flags_q), .thread_wait_i(thread_wait_i),
    .idle_i(disp_vld_o == '0), .code_o(code)
  );
  assign stall_code_o = code;

  // new causes survive a same-cycle clear
  assign flags_n = (flags_q & ~clr_i) | (c_flags[FETCH_W] & ~flags_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC[PC_W-1:0];
      ret_q   <= '0;
      dly_q   <= '0;
      flags_q <= '0;
    end else begin
      pc_q    <= (clr_i[F_BR] && flags_q[F_BR]) ? redirect_pc_i : c_pc[FETCH_W];
      ret_q   <= c_ret[FETCH_W];
      dly_q   <= c_dly[FETCH_W];
      flags_q <= flags_n;
    end
  end

  AST_EXC_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_pend_i |-> disp_vld_o == '0);  // R1
  AST_FREE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(disp_vld_o) <= int'(free_i));  // R2
  AST_BR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[F_BR] |-> (stall_code_o == SC_BR_THR || stall_code_o == SC_BRANCH));  // R3
  AST_ADR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_err_o |=> flags_q[F_XL]);  // R4
  AST_IC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[F_IC] && !clr_i[F_IC]) |=> flags_q[F_IC]);  // R5
  AST_BR_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_req_o |=> flags_q[F_BR]);  // R6
  AST_ILL_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_ill_o != '0) |=> flags_q[F_EXC]);  // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q != '0) |-> disp_vld_o == '0);  // R10
endmodule

// File: tb/fetch_ctrl_tb.sv
module fetch_ctrl_tb;
  localparam int FW = 4, SL = 1, WD = 16, PW = 32, CW = $clog2(WD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          exc_pend, likely_vld, thread_wait;
  logic [CW-1:0] occ, free;
  logic [3*FW-1:0] cls;
  logic [2*FW-1:0] rsp;
  logic [PW-1:0] likely_pc, redirect_pc;
  logic [7:0]    clr;
  logic [FW-1:0] disp_vld, disp_flush, disp_ill;
  logic [PW*FW-1:0] disp_pc;
  logic [PW-1:0] pc, ret_pc;
  logic [3:0]    code;
  logic          br_req, adr_err;

  fetch_ctrl #(.FETCH_W(FW), .SLOTS(SL), .WIN_DEPTH(WD), .PC_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .exc_pend_i(exc_pend), .occ_i(occ), .free_i(free),
    .cls_i(cls), .rsp_i(rsp), .likely_vld_i(likely_vld), .likely_pc_i(likely_pc),
    .thread_wait_i(thread_wait), .clr_i(clr), .redirect_pc_i(redirect_pc),
    .disp_vld_o(disp_vld), .disp_pc_o(disp_pc), .disp_flush_o(disp_flush),
    .disp_ill_o(disp_ill), .pc_o(pc), .stall_code_o(code), .br_req_o(br_req),
    .ret_pc_o(ret_pc), .adr_err_o(adr_err));

  int checks = 0, fails = 0;
  logic [PW-1:0] m_pc = 32'h100, m_ret = '0;
  int m_dly = 0;
  logic [7:0] m_flags = '0;
  logic [FW-1:0] e_vld, e_flush, e_ill;
  logic e_br, e_adr;
  logic [PW-1:0] e_ret, n_pc;
  logic [3:0] e_code;
  logic [7:0] n_flags;
  int n_dly;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_eval();
    logic [PW-1:0] p = m_pc, r = m_ret, spc;
    logic [7:0] fl = m_flags;
    int d = m_dly, n = 0;
    bit run = !exc_pend;
    logic [2:0] c;
    e_vld = '0; e_flush = '0; e_ill = '0; e_br = 0; e_adr = 0;
    for (int s = 0; s < FW; s++) begin
      c = cls[3*s +: 3];
      if (!run) continue;
      if (fl != 0 || int'(occ) + n >= WD || n >= int'(free)) begin run = 0; continue; end
      if (p[1:0] != 0) begin e_adr = 1; fl[3] = 1; run = 0; continue; end
      if (rsp[2*s +: 2] == 2'd1) continue;
      if (rsp[2*s +: 2] == 2'd2) begin fl[2] = 1; run = 0; continue; end
      if (rsp[2*s +: 2] == 2'd3) begin fl[3] = 1; run = 0; continue; end
      e_vld[s] = 1; n++;
      if (d != 0 && c == 3'd1) begin c = 3'd6; e_ill[s] = 1; end
      spc = p; p = p + 4;
      case (c)
        3'd1: begin d = SL + 1; r = spc + 4 * (SL + 1); end
        3'd2: begin fl[5] = 1; e_flush[s] = 1; end
        3'd3: begin fl[6] = 1; e_flush[s] = 1; end
        3'd4: begin fl[1] = 1; e_flush[s] = 1; end
        3'd5: fl[7] = 1;
        3'd6: fl[4] = 1;
        default: ;
      endcase
      if (d != 0) begin
        d--;
        if (d == 0) begin
          if (likely_vld) p = likely_pc;
          else begin fl[0] = 1; e_br = 1; end
        end
      end
      if (fl != 0) run = 0;
    end
    e_ret = r;
    if (m_flags[0]) e_code = thread_wait ? 4'd1 : 4'd2;
    else if (m_flags[1]) e_code = 4'd3;
    else if (m_flags[2]) e_code = 4'd4;
    else if (m_flags[3]) e_code = 4'd5;
    else if (m_flags[4]) e_code = 4'd6;
    else if (m_flags[5]) e_code = 4'd7;
    else if (m_flags[6]) e_code = 4'd8;
    else if (m_flags[7]) e_code = 4'd9;
    else e_code = (e_vld == 0) ? 4'd10 : 4'd0;
    n_pc = (clr[0] && m_flags[0]) ? redirect_pc : p;
    n_flags = (m_flags & ~clr) | (fl & ~m_flags);
    n_dly = d;
  endtask

  // inputs already set at negedge; compare, then step model at posedge
  task automatic cyc(string tag);
    #1;
    model_eval();
    chk({tag, " vld"}, 32'(disp_vld), 32'(e_vld));
    chk({tag, " code"}, 32'(code), 32'(e_code));
    chk({tag, " pc"}, pc, m_pc);
    chk({tag, " flush"}, 32'(disp_flush), 32'(e_flush));
    chk({tag, " ill"}, 32'(disp_ill), 32'(e_ill));
    chk({tag, " brq"}, 32'(br_req), 32'(e_br));
    chk({tag, " adr"}, 32'(adr_err), 32'(e_adr));
    if (e_br) chk({tag, " ret"}, ret_pc, e_ret);
    @(posedge clk);
    m_pc = n_pc; m_flags = n_flags; m_dly = n_dly; m_ret = e_ret;
    @(negedge clk);
  endtask

  task automatic idle_in();
    exc_pend = 0; occ = 0; free = CW'(WD); cls = '0; rsp = '0;
    likely_vld = 0; likely_pc = 32'h400; thread_wait = 0; clr = '0; redirect_pc = 32'h200;
  endtask

  function automatic logic [3*FW-1:0] cl(int a, int b, int c, int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd77));
    idle_in();
    exc_pend = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R10 reset pc", pc, 32'h100);
    chk("R1 exc blocks", 32'(disp_vld), 0);
    chk("R3 idle code other", 32'(code), 10);
    cyc("R1");
    idle_in(); cyc("R10 plain");
    chk("R10 pc adv", pc, 32'h110);
    free = 2; cyc("R2 free");
    free = CW'(WD); occ = 15; cyc("R2 occ");
    occ = 0; rsp = 8'b0000_0100; cyc("R5 refuse");
    rsp = '0;
    cls = cl(1, 0, 0, 0); cyc("R6 branch");
    cls = '0; thread_wait = 1; cyc("R3 br thr");
    thread_wait = 0; cyc("R3 br");
    clr = 8'h01; redirect_pc = 32'h200; cyc("R6 redirect");
    clr = 0; #1 chk("R6 pc redirected", pc, 32'h200); #0;
    cls = cl(1, 0, 0, 0); likely_vld = 1; cyc("R7 likely");
    likely_vld = 0; cls = cl(1, 1, 0, 0); cyc("R8 br in slot");
    cls = '0; cyc("R3 br over exc");
    clr = 8'h01; cyc("R8 clr br");
    clr = 0; cyc("R8 exc code");
    clr = 8'h10; cyc("R10 clr exc");
    clr = 0; cls = cl(0, 2, 0, 0); cyc("R9 sys");
    cls = '0; clr = 8'h20; cyc("R9 clr");
    clr = 0; cls = cl(5, 0, 0, 0); cyc("R9 sc");
    clr = 8'h80; cls = '0; cyc("R9 clr sc");
    clr = 0; cls = cl(4, 3, 0, 0); cyc("R9 fpc");
    clr = 8'h02; cls = '0; cyc("R9 clr fpc");
    clr = 0; rsp = 8'b0000_1000; cyc("R5 miss");
    rsp = '0; cyc("R5 sticky"); cyc("R5 sticky");
    clr = 8'h04; cyc("R5 clr");
    clr = 0; rsp = 8'b0000_0011; cyc("R5 fault");
    rsp = '0; clr = 8'h08; cyc("R5 clr xl");
    clr = 0; cls = cl(1, 0, 0, 0); cyc("R4 br");
    cls = '0; clr = 8'h01; redirect_pc = 32'h302; cyc("R4 redir");
    clr = 0; cyc("R4 misalign");
    clr = 8'h09; redirect_pc = 32'h300; cyc("R4 clr");
    clr = 0;
    for (int i = 0; i < 4000; i++) begin
      exc_pend = ($urandom % 20) == 0;
      occ = CW'($urandom % (WD + 1));
      free = CW'($urandom % (WD + 1));
      for (int s = 0; s < FW; s++) begin
        int k = $urandom % 16;
        cls[3*s +: 3] = (k < 9) ? 3'd0 : 3'(k - 8);
        k = $urandom % 16;
        rsp[2*s +: 2] = (k < 13) ? 2'd0 : 2'(k - 12);
      end
      likely_vld = $urandom % 2;
      likely_pc = {$urandom % 1024, 2'b00} + (($urandom % 30 == 0) ? 32'd2 : 32'd0);
      redirect_pc = {$urandom % 1024, 2'b00};
      thread_wait = $urandom % 2;
      clr = 8'($urandom) & 8'($urandom);
      cyc("R1 R2 R3 R10 rnd");
    end
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule